// File: doc/BRIEF.md
# Two-Wire Serial Receive Target with General-Call Response

This block is the target (slave) side of a two-wire serial bus. It watches the clock line SCL and the data line SDA, both already synchronized to the system clock. It finds START, repeated START and STOP conditions and shifts in a 7-bit address followed by a direction bit. The target acknowledges its programmable address. When the application enables it, the target also acknowledges the all-zero general-call address, but only if that address is followed by a Write bit.

After a write address is accepted, the target receives each data byte and shows it on a parallel output, with a one-cycle valid strobe. The application can refuse the current byte, which ends reception. After a read address is accepted, the target shifts a byte from a parallel input out onto SDA. It continues byte by byte until the controller answers with a NACK.

SDA is modelled as an open-drain drive-low enable. The target changes SDA only while SCL is low. The whole block runs on the system clock, and each SCL edge is found by comparing the line with its value in the previous cycle.

Top module: `i2c_gc_target`

## Requirements
- R1: Address bytes are shifted in most significant bit first, one bit per SCL rising edge. The 7-bit address comes first, then the direction bit (0 = write, 1 = read). If the address equals `own_addr_i` (and is neither 0000000 nor 1111xxx), the target holds `sda_drive_low_o` high through the ninth SCL clock of the address byte.
- R2: When `gc_enable_i` is 1, the address 0000000 followed by a Write bit is acknowledged. Followed by a Read bit, it is never acknowledged, and the target drives no read data. When `gc_enable_i` is 0, the general-call address is not acknowledged.
- R3: An address whose upper four bits are 1111 is never acknowledged, even when `own_addr_i` holds that value.
- R4: After an address that is not acknowledged, SDA stays released and no byte is presented until the next START or STOP.
- R5: Each write data byte, assembled MSB first, appears on `rx_data_o`. It comes with a `rx_valid_o` pulse exactly one system clock long, issued when SCL falls after the byte's eighth bit.
- R6: A write data byte is acknowledged unless `rx_last_i` is 1 when SCL falls after its eighth bit. In that case the byte is still presented, the ninth slot is left released (NACK), and later bytes are ignored until START or STOP.
- R7: On an accepted read, the target captures `tx_data_i` when SCL falls at the end of the address acknowledge slot, and again at the end of every slot in which the controller acknowledges. Each capture pulses `tx_load_o` for one cycle, and the byte is driven MSB first. A controller NACK ends the transfer, and SDA stays released until START or STOP.
- R8: `sda_drive_low_o` changes only while SCL is low, and it is released in the ninth slot of a read byte.
- R9: A START seen in any state, including in the middle of a byte, restarts address reception from bit 0. A STOP returns the target to idle with SDA released.
- R10: `gc_flag_o` is 1 from the acknowledged general-call address until the next START or STOP. It is 0 for a transfer to the target's own address.
- R11: After reset, `sda_drive_low_o`, `rx_valid_o`, `tx_load_o` and `gc_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| sda_drive_low_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| own_addr_i | input | ADDR_W | Target's own 7-bit address |
| gc_enable_i | input | 1 | Enables general-call acknowledge |
| rx_last_i | input | 1 | Refuse (NACK) the byte now completing |
| rx_data_o | output | DATA_W | Last received write byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| tx_data_i | input | DATA_W | Byte to return on a read |
| tx_load_o | output | 1 | One-cycle strobe when `tx_data_i` is captured |
| gc_flag_o | output | 1 | Current transfer was addressed by general call |

## Verification
The bench builds the block with its default parameters: a 7-bit address, 8-bit data and general-call support generated in. Because the support is present, switching `gc_enable_i` at run time reaches both the acknowledged and the refused general-call paths, and the Read-bit variant as well. Its bus-level controller model predicts the drive-low enable for every SCL high phase. With that prediction it covers the reserved group programmed as the own address, application-refused bytes, a controller NACK ending a read, and repeated START and STOP issued in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_WAIT
   } tgt_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic scl_lvl;
   } bus_evt_t;

endpackage

// File: rtl/i2c_tgt_bus_events.sv
module i2c_tgt_bus_events
   import i2c_tgt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      evt_o.rise    = scl_i & ~scl_q;
      evt_o.fall    = ~scl_i & scl_q;
      evt_o.start   = scl_i & scl_q & sda_q & ~sda_i;
      evt_o.stop    = scl_i & scl_q & ~sda_q & sda_i;
      evt_o.scl_lvl = scl_q;
   end

endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match #(
   parameter int ADDR_W     = 7,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rw_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_enable_i,
   output logic              own_hit_o,
   output logic              gc_hit_o
);

   localparam int           RSV_BITS = 4;
   localparam logic [RSV_BITS-1:0] RSV_TAG = '1;

   logic reserved;
   logic is_zero;

   assign reserved  = (addr_i[ADDR_W-1 -: RSV_BITS] == RSV_TAG);
   assign is_zero   = (addr_i == '0);
   assign own_hit_o = (addr_i == own_addr_i) && !reserved && !is_zero;

   generate
      if (GC_SUPPORT) begin : g_gc
         assign gc_hit_o = gc_enable_i && is_zero && !rw_i;
      end else begin : g_no_gc
         logic unused_gc;
         assign unused_gc = gc_enable_i ^ rw_i;
         assign gc_hit_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic              sda_i,
   input  logic              own_hit_i,
   input  logic              gc_hit_i,
   output logic [DATA_W-1:0] addr_byte_o,
   input  logic              rx_last_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              sda_drive_low_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              tx_load_o,
   output logic              gc_flag_o
);

   localparam int              CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   tgt_state_e        state_q;
   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              drive_q;
   logic [DATA_W-1:0] rx_q;
   logic              rxv_q;
   logic              txl_q;
   logic              gc_q;
   logic              rw_q;
   logic              refuse_q;
   logic              mnack_q;
   logic              byte_full;

   assign byte_full   = (cnt_q == FULL_CNT);
   assign addr_byte_o = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sh_q     <= '0;
         cnt_q    <= '0;
         drive_q  <= 1'b0;
         rx_q     <= '0;
         rxv_q    <= 1'b0;
         txl_q    <= 1'b0;
         gc_q     <= 1'b0;
         rw_q     <= 1'b0;
         refuse_q <= 1'b0;
         mnack_q  <= 1'b0;
      end else begin
         rxv_q <= 1'b0;
         txl_q <= 1'b0;
         if (evt_i.stop) begin
            state_q <= ST_IDLE;
            drive_q <= 1'b0;
            gc_q    <= 1'b0;
            cnt_q   <= '0;
         end else if (evt_i.start) begin
            state_q <= ST_ADDR;
            drive_q <= 1'b0;
            gc_q    <= 1'b0;
            cnt_q   <= '0;
         end else begin
            unique case (state_q)
               ST_ADDR: begin
                  if (evt_i.rise) begin
                     sh_q  <= {sh_q[DATA_W-2:0], sda_i};
                     cnt_q <= cnt_q + ONE_CNT;
                  end else if (evt_i.fall && byte_full) begin
                     if (own_hit_i || gc_hit_i) begin
                        drive_q <= 1'b1;
                        gc_q    <= gc_hit_i;
                        rw_q    <= sh_q[0];
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_WAIT;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (evt_i.fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        sh_q    <= tx_data_i;
                        drive_q <= ~tx_data_i[DATA_W-1];
                        txl_q   <= 1'b1;
                        state_q <= ST_RD;
                     end else begin
                        drive_q <= 1'b0;
                        state_q <= ST_WR;
                     end
                  end
               end
               ST_WR: begin
                  if (evt_i.rise) begin
                     sh_q  <= {sh_q[DATA_W-2:0], sda_i};
                     cnt_q <= cnt_q + ONE_CNT;
                  end else if (evt_i.fall && byte_full) begin
                     rx_q     <= sh_q;
                     rxv_q    <= 1'b1;
                     drive_q  <= ~rx_last_i;
                     refuse_q <= rx_last_i;
                     state_q  <= ST_WR_ACK;
                  end
               end
               ST_WR_ACK: begin
                  if (evt_i.fall) begin
                     drive_q <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= refuse_q ? ST_WAIT : ST_WR;
                  end
               end
               ST_RD: begin
                  if (evt_i.rise) begin
                     cnt_q <= cnt_q + ONE_CNT;
                  end else if (evt_i.fall) begin
                     if (byte_full) begin
                        drive_q <= 1'b0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        drive_q <= ~sh_q[DATA_W-2];
                        sh_q    <= {sh_q[DATA_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (evt_i.rise) begin
                     mnack_q <= sda_i;
                  end else if (evt_i.fall) begin
                     cnt_q <= '0;
                     if (mnack_q) begin
                        state_q <= ST_WAIT;
                     end else begin
                        sh_q    <= tx_data_i;
                        drive_q <= ~tx_data_i[DATA_W-1];
                        txl_q   <= 1'b1;
                        state_q <= ST_RD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_drive_low_o = drive_q;
   assign rx_data_o       = rx_q;
   assign rx_valid_o      = rxv_q;
   assign tx_load_o       = txl_q;
   assign gc_flag_o       = gc_q;

   AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_q != $past(drive_q)) |-> !evt_i.scl_lvl); // R8
   AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R5
   AST_RSV_NEVER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && evt_i.fall && byte_full && sh_q[DATA_W-1 -: 4] == 4'hF)
      |=> !drive_q); // R3
   AST_GC_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && evt_i.fall && byte_full && sh_q[DATA_W-1:1] == '0 && sh_q[0])
      |=> !drive_q); // R2
   AST_GC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      gc_flag_o |-> (state_q != ST_RD)); // R2
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.stop |=> (!sda_drive_low_o && !gc_flag_o && state_q == ST_IDLE)); // R9

endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low_o,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_enable_i,
   input  logic              rx_last_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_load_o,
   output logic              gc_flag_o
);

   generate
      if (ADDR_W != 7) begin : g_chk_addr
         $error("i2c_gc_target: ADDR_W must be 7");
      end
      if (DATA_W != ADDR_W + 1) begin : g_chk_data
         $error("i2c_gc_target: DATA_W must equal ADDR_W + 1");
      end
   endgenerate

   bus_evt_t          evt;
   logic [DATA_W-1:0] addr_byte;
   logic              own_hit;
   logic              gc_hit;

   i2c_tgt_bus_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   i2c_tgt_addr_match #(
      .ADDR_W     (ADDR_W),
      .GC_SUPPORT (GC_SUPPORT)
   ) u_match (
      .addr_i      (addr_byte[DATA_W-1:1]),
      .rw_i        (addr_byte[0]),
      .own_addr_i  (own_addr_i),
      .gc_enable_i (gc_enable_i),
      .own_hit_o   (own_hit),
      .gc_hit_o    (gc_hit)
   );

   i2c_tgt_fsm #(
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .evt_i           (evt),
      .sda_i           (sda_i),
      .own_hit_i       (own_hit),
      .gc_hit_i        (gc_hit),
      .addr_byte_o     (addr_byte),
      .rx_last_i       (rx_last_i),
      .tx_data_i       (tx_data_i),
      .sda_drive_low_o (sda_drive_low_o),
      .rx_data_o       (rx_data_o),
      .rx_valid_o      (rx_valid_o),
      .tx_load_o       (tx_load_o),
      .gc_flag_o       (gc_flag_o)
   );

endmodule

// File: tb/i2c_gc_target_test.sv
module i2c_gc_target_test;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = CLK_PERIOD / 4;
   localparam int WD_CYCLES  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_bus;
   logic       sda_drive_low_o;
   logic [6:0] own_addr = 7'h3A;
   logic       gc_en = 1'b0;
   logic       rx_last = 1'b0;
   logic [7:0] rx_data_o;
   logic       rx_valid_o;
   logic [7:0] tx_data = 8'h00;
   logic       tx_load_o;
   logic       gc_flag_o;

   int    vectors = 0;
   int    fails = 0;
   int    tx_loads = 0;
   bit    done = 1'b0;
   logic  chk_drv = 1'b0;
   logic  exp_drv = 1'b0;
   string cur_req = "R11";
   logic [7:0] exp_rx[$];

   assign sda_bus = m_sda & ~sda_drive_low_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2c_gc_target uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (sda_bus),
      .sda_drive_low_o (sda_drive_low_o),
      .own_addr_i      (own_addr),
      .gc_enable_i     (gc_en),
      .rx_last_i       (rx_last),
      .rx_data_o       (rx_data_o),
      .rx_valid_o      (rx_valid_o),
      .tx_data_i       (tx_data),
      .tx_load_o       (tx_load_o),
      .gc_flag_o       (gc_flag_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the bus model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (chk_drv) begin
            vectors++;
            if (sda_drive_low_o !== exp_drv) begin
               fails++;
               $display("FAIL %s: sda_drive_low_o actual %0b expected %0b",
                        cur_req, sda_drive_low_o, exp_drv);
            end
         end
         if (rx_valid_o) begin
            vectors++;
            if (exp_rx.size() == 0) begin
               fails++;
               $display("FAIL %s: unexpected rx byte actual %0h expected none", cur_req, rx_data_o);
            end else begin
               logic [7:0] e;
               e = exp_rx.pop_front();
               if (rx_data_o !== e) begin
                  fails++;
                  $display("FAIL %s: rx_data_o actual %0h expected %0h", cur_req, rx_data_o, e);
               end
            end
         end
         if (tx_load_o) tx_loads++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #(QTR);
   endtask

   task automatic clk_bit(input logic mb, input logic expd, output logic seen);
      m_sda = mb;
      tick(2);
      scl = 1'b1;
      exp_drv = expd;
      tick(1);
      chk_drv = 1'b1;
      tick(1);
      seen = sda_bus;
      tick(2);
      chk_drv = 1'b0;
      scl = 1'b0;
      tick(2);
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      tick(2);
      scl = 1'b1;
      tick(2);
      m_sda = 1'b0;
      tick(2);
      scl = 1'b0;
      tick(2);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      tick(2);
      scl = 1'b1;
      tick(2);
      m_sda = 1'b1;
      tick(3);
   endtask

   function automatic logic model_ack(input logic [6:0] a, input logic rw);
      if (a[6:3] == 4'hF) return 1'b0;
      if (a == 7'd0) return !rw && gc_en;
      return a == own_addr;
   endfunction

   task automatic write_byte(input logic [7:0] b, input logic ack_exp);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, s);
      clk_bit(1'b1, ack_exp, s);
      check({cur_req, " ack slot"}, {7'd0, !s}, {7'd0, ack_exp});
   endtask

   task automatic send_addr(input logic [6:0] a, input logic rw);
      write_byte({a, rw}, model_ack(a, rw));
   endtask

   task automatic read_byte(input logic [7:0] b, input logic m_ack, input logic [7:0] nxt);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, ~b[i], s);
         check({cur_req, " read bit"}, {7'd0, s}, {7'd0, b[i]});
         if (i == 7) tx_data = nxt;
      end
      clk_bit(m_ack ? 1'b0 : 1'b1, 1'b0, s);
   endtask

   initial begin
      int loads0;
      logic s;
      tick(4);
      // R11: reset state
      cur_req = "R11";
      check("R11 drive", {7'd0, sda_drive_low_o}, 8'd0);
      check("R11 rx_valid", {7'd0, rx_valid_o}, 8'd0);
      check("R11 tx_load", {7'd0, tx_load_o}, 8'd0);
      check("R11 gc_flag", {7'd0, gc_flag_o}, 8'd0);
      rst_n = 1'b1;
      tick(3);
      check("R11 drive after release", {7'd0, sda_drive_low_o}, 8'd0);

      // R1 R5: own address write, several patterns
      cur_req = "R1";
      bus_start();
      send_addr(own_addr, 1'b0);
      check("R10 own gc_flag", {7'd0, gc_flag_o}, 8'd0);
      cur_req = "R5";
      foreach (exp_rx[i]) ;
      exp_rx.push_back(8'hA5); write_byte(8'hA5, 1'b1);
      exp_rx.push_back(8'h3C); write_byte(8'h3C, 1'b1);
      exp_rx.push_back(8'hFF); write_byte(8'hFF, 1'b1);
      exp_rx.push_back(8'h01); write_byte(8'h01, 1'b1);
      bus_stop();

      // R6: application refuses second byte, third ignored
      cur_req = "R6";
      bus_start();
      send_addr(own_addr, 1'b0);
      exp_rx.push_back(8'h11); write_byte(8'h11, 1'b1);
      rx_last = 1'b1;
      exp_rx.push_back(8'h22); write_byte(8'h22, 1'b0);
      rx_last = 1'b0;
      write_byte(8'h33, 1'b0);
      bus_stop();

      // R2 R10: general call write enabled
      cur_req = "R2";
      gc_en = 1'b1;
      bus_start();
      send_addr(7'd0, 1'b0);
      check("R10 gc_flag set", {7'd0, gc_flag_o}, 8'd1);
      exp_rx.push_back(8'h5E); write_byte(8'h5E, 1'b1);
      bus_stop();
      check("R10 gc_flag cleared by stop", {7'd0, gc_flag_o}, 8'd0);

      // R2: general call with Read bit, no data driven
      cur_req = "R2";
      loads0 = tx_loads;
      tx_data = 8'h00;
      bus_start();
      send_addr(7'd0, 1'b1);
      for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, s);
      bus_stop();
      check("R2 no tx load on gc read", 8'(tx_loads - loads0), 8'd0);

      // R2: general call refused when disabled
      gc_en = 1'b0;
      bus_start();
      send_addr(7'd0, 1'b0);
      write_byte(8'h44, 1'b0);
      bus_stop();

      // R3: reserved group programmed as own address
      cur_req = "R3";
      own_addr = 7'h7B;
      bus_start();
      send_addr(7'h7B, 1'b0);
      write_byte(8'h99, 1'b0);
      bus_stop();
      own_addr = 7'h3A;

      // R4: other address ignored
      cur_req = "R4";
      bus_start();
      send_addr(7'h15, 1'b0);
      write_byte(8'h77, 1'b0);
      bus_stop();

      // R7 R8: read from own address, ACK then NACK
      cur_req = "R7";
      loads0 = tx_loads;
      tx_data = 8'h96;
      bus_start();
      send_addr(own_addr, 1'b1);
      read_byte(8'h96, 1'b1, 8'h5A);
      read_byte(8'h5A, 1'b0, 8'hC0);
      for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, s);
      bus_stop();
      check("R7 tx_load count", 8'(tx_loads - loads0), 8'd2);

      // R9 R10: repeated start from write to read, then mid-byte restart
      cur_req = "R9";
      gc_en = 1'b1;
      bus_start();
      send_addr(7'd0, 1'b0);
      exp_rx.push_back(8'h6D); write_byte(8'h6D, 1'b1);
      tx_data = 8'h81;
      bus_start();
      check("R10 gc_flag cleared by rep start", {7'd0, gc_flag_o}, 8'd0);
      send_addr(own_addr, 1'b1);
      read_byte(8'h81, 1'b0, 8'h00);
      bus_start();
      send_addr(own_addr, 1'b0);
      clk_bit(1'b1, 1'b0, s);
      clk_bit(1'b0, 1'b0, s);
      clk_bit(1'b1, 1'b0, s);
      bus_start();
      send_addr(own_addr, 1'b0);
      exp_rx.push_back(8'hC3); write_byte(8'hC3, 1'b1);
      // stop in the middle of a data byte
      clk_bit(1'b0, 1'b0, s);
      clk_bit(1'b1, 1'b0, s);
      bus_stop();
      check("R9 released after stop", {7'd0, sda_drive_low_o}, 8'd0);
      bus_start();
      send_addr(own_addr, 1'b0);
      exp_rx.push_back(8'h0F); write_byte(8'h0F, 1'b1);
      bus_stop();

      tick(4);
      check("R5 all expected bytes seen", 8'(exp_rx.size()), 8'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule